// File: doc/BRIEF.md
# Integer ALU with Signed and Unsigned Compare

This block is the integer arithmetic and logic unit of a load/store RISC core. Each cycle it takes two 32-bit operands, a 5-bit shift amount and a 4-bit operation code. One clock edge later it presents a 32-bit result, a flag that is set when that result is zero, and a flag that reports signed overflow.

The operations are:

- add and subtract, each in a trapping form and a non-trapping form;
- the bitwise operations AND, OR, XOR and NOR;
- set-less-than as a signed compare and as an unsigned compare;
- shift left, shift right with zero fill, and shift right with sign fill.

The trapping and non-trapping forms use the same adder and give the same sum. They differ in one way: only the trapping forms may raise the overflow flag. The signed and unsigned compares also use that adder, through a subtraction. The exception logic that acts on overflow sits outside this block. A branch unit reads the zero flag for its equal and not-equal decisions.

The core is combinational and a single register stage sits behind it. This suits an execute stage whose outputs are registered, as in an FPGA pipeline.

Top module: `int_alu`

## Requirements
- R1: All three outputs come from registers. An input applied before clock edge k shows on the outputs after edge k. While the synchronous active-high reset `rst` is sampled high, the result, zero flag and overflow flag are all cleared to 0.
- R2: Code 0 (trapping add) and code 1 (non-trapping add) produce A+B modulo 2^32. Code 2 (trapping subtract) and code 3 (non-trapping subtract) produce A-B modulo 2^32.
- R3: The overflow flag is set for code 0 exactly when A and B have the same sign bit and the sum's sign bit differs from it. It is set for code 2 exactly when A and B have different sign bits and the difference's sign bit differs from A's.
- R4: The overflow flag stays 0 for codes 1 and 3 and for every code other than 0 and 2, whatever the operands.
- R5: Code 8 yields 1 when A < B as two's-complement numbers and 0 otherwise. Code 9 yields 1 when A < B as unsigned numbers and 0 otherwise. For example, A=1 with B=0xFFFFFFFF gives 0 for code 8 and 1 for code 9. Bits 31:1 of the result are always 0 for these two codes.
- R6: For codes 0 to 12, the zero flag is 1 exactly when the registered 32-bit result is 0.
- R7: Code 10 shifts A left, code 11 shifts A right with zero fill, and code 12 shifts A right filling with A's bit 31. The amount is the 5-bit shift input (0 to 31), and B is ignored. An amount of 0 returns A unchanged.
- R8: Code 4 gives A&B, code 5 gives A|B, code 6 gives A^B and code 7 gives ~(A|B). All 32 bits are driven.
- R9: Codes 13, 14 and 15 give a result of 0 with both the zero flag and the overflow flag at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code (0 to 12 used; 13 to 15 give a quiet zero) |
| opnd_a | input | 32 | First operand; the value that is shifted |
| opnd_b | input | 32 | Second operand |
| shamt | input | 5 | Shift amount |
| res_q | output | 32 | Registered result |
| zero_q | output | 1 | Registered flag: result is zero |
| ovf_q | output | 1 | Registered signed-overflow flag |

## Verification
The block has no state beyond its output register, so a fault in the datapath or in decoding shows on the very next cycle's outputs and nowhere later.

The cases that stress the design are these:

- the sign-boundary operands 0x7FFFFFFF and 0x80000000, which are where a swapped carry term or a swapped overflow term shows;
- compare pairs whose order changes between the signed and unsigned readings;
- shift amounts of 0, 1 and 31 applied to a negative operand.

A mis-decoded operation code gives a wrong result or a spurious flag right away.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_ADD_T = 4'd0;
  localparam logic [OP_W-1:0] OP_ADD_W = 4'd1;
  localparam logic [OP_W-1:0] OP_SUB_T = 4'd2;
  localparam logic [OP_W-1:0] OP_SUB_W = 4'd3;
  localparam logic [OP_W-1:0] OP_AND   = 4'd4;
  localparam logic [OP_W-1:0] OP_OR    = 4'd5;
  localparam logic [OP_W-1:0] OP_XOR   = 4'd6;
  localparam logic [OP_W-1:0] OP_NOR   = 4'd7;
  localparam logic [OP_W-1:0] OP_LT_S  = 4'd8;
  localparam logic [OP_W-1:0] OP_LT_U  = 4'd9;
  localparam logic [OP_W-1:0] OP_SHL   = 4'd10;
  localparam logic [OP_W-1:0] OP_SHR   = 4'd11;
  localparam logic [OP_W-1:0] OP_SHRA  = 4'd12;
  localparam logic [OP_W-1:0] OP_LAST  = OP_SHRA;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_fn_e;

  typedef enum logic [2:0] {
    CL_ARITH,
    CL_LOGIC,
    CL_CMP,
    CL_SHIFT,
    CL_NONE
  } op_class_e;

endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             do_sub,
  output logic [WIDTH-1:0] sum,
  output logic             ovf,
  output logic             lt_signed,
  output logic             lt_unsigned
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  always_comb begin
    b_eff = do_sub ? ~b : b;
    full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, do_sub};
    sum   = full[MSB:0];
    // Operand signs agree (after inversion for subtract) but the result sign differs.
    ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    // Valid when do_sub is set: the sign of the true difference.
    lt_signed   = sum[MSB] ^ ovf;
    // No carry out of a + ~b + 1 means a borrow, so a < b unsigned.
    lt_unsigned = ~full[WIDTH];
  end

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]            a,
  input  logic [WIDTH-1:0]            b,
  input  int_alu_pkg::logic_fn_e      fn,
  output logic [WIDTH-1:0]            y
);

  import int_alu_pkg::*;

  always_comb begin
    unique case (fn)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      LG_NOR:  y = ~(a | b);
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SHW-1:0]   amt,
  input  logic             left,
  input  logic             arith,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] rev_in;
  logic [WIDTH-1:0] rev_out;
  logic [WIDTH-1:0] stg [SHW+1];
  logic             fill;

  // Left shifts run on the bit-reversed operand through the right shifter.
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign rev_in[i]  = din[WIDTH-1-i];
    assign rev_out[i] = stg[SHW][WIDTH-1-i];
  end

  assign fill   = arith & ~left & din[WIDTH-1];
  assign stg[0] = left ? rev_in : din;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 2 ** s;
    assign stg[s+1] = amt[s] ? {{STEP{fill}}, stg[s][WIDTH-1:STEP]} : stg[s];
  end

  assign dout = left ? rev_out : stg[SHW];

endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [int_alu_pkg::OP_W-1:0] op_sel,
  input  logic [WIDTH-1:0]             opnd_a,
  input  logic [WIDTH-1:0]             opnd_b,
  input  logic [SHW-1:0]               shamt,
  output logic [WIDTH-1:0]             res_q,
  output logic                         zero_q,
  output logic                         ovf_q
);

  import int_alu_pkg::*;

  op_class_e        cls;
  logic             do_sub;
  logic             trap_form;
  logic             sh_left;
  logic             sh_arith;
  logic_fn_e        lfn;

  logic [WIDTH-1:0] as_sum;
  logic             as_ovf;
  logic             as_lt_s;
  logic             as_lt_u;
  logic [WIDTH-1:0] lg_y;
  logic [WIDTH-1:0] sh_y;

  logic [WIDTH-1:0] res_d;
  logic             zero_d;
  logic             ovf_d;

  // Decode the operation code into a class and per-unit controls.
  always_comb begin
    cls       = CL_NONE;
    do_sub    = 1'b0;
    trap_form = 1'b0;
    sh_left   = 1'b0;
    sh_arith  = 1'b0;
    lfn       = LG_AND;
    case (op_sel)
      OP_ADD_T: begin cls = CL_ARITH; trap_form = 1'b1; end
      OP_ADD_W: begin cls = CL_ARITH; end
      OP_SUB_T: begin cls = CL_ARITH; do_sub = 1'b1; trap_form = 1'b1; end
      OP_SUB_W: begin cls = CL_ARITH; do_sub = 1'b1; end
      OP_AND:   begin cls = CL_LOGIC; lfn = LG_AND; end
      OP_OR:    begin cls = CL_LOGIC; lfn = LG_OR; end
      OP_XOR:   begin cls = CL_LOGIC; lfn = LG_XOR; end
      OP_NOR:   begin cls = CL_LOGIC; lfn = LG_NOR; end
      OP_LT_S:  begin cls = CL_CMP; do_sub = 1'b1; end
      OP_LT_U:  begin cls = CL_CMP; do_sub = 1'b1; end
      OP_SHL:   begin cls = CL_SHIFT; sh_left = 1'b1; end
      OP_SHR:   begin cls = CL_SHIFT; end
      OP_SHRA:  begin cls = CL_SHIFT; sh_arith = 1'b1; end
      default:  cls = CL_NONE;
    endcase
  end

  int_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a           (opnd_a),
    .b           (opnd_b),
    .do_sub      (do_sub),
    .sum         (as_sum),
    .ovf         (as_ovf),
    .lt_signed   (as_lt_s),
    .lt_unsigned (as_lt_u)
  );

  int_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a  (opnd_a),
    .b  (opnd_b),
    .fn (lfn),
    .y  (lg_y)
  );

  int_alu_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
    .din   (opnd_a),
    .amt   (shamt),
    .left  (sh_left),
    .arith (sh_arith),
    .dout  (sh_y)
  );

  // Select the result and form the flags.
  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    case (cls)
      CL_ARITH: begin
        res_d = as_sum;
        ovf_d = trap_form & as_ovf;
      end
      CL_LOGIC: res_d = lg_y;
      CL_CMP:   res_d = {{(WIDTH-1){1'b0}}, (op_sel == OP_LT_U) ? as_lt_u : as_lt_s};
      CL_SHIFT: res_d = sh_y;
      default:  res_d = '0;
    endcase
    zero_d = (cls != CL_NONE) && (res_d == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      zero_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      res_q  <= res_d;
      zero_q <= zero_d;
      ovf_q  <= ovf_d;
    end
  end

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input logic                         clk,
  input logic                         rst,
  input logic [int_alu_pkg::OP_W-1:0] op_sel,
  input logic [WIDTH-1:0]             opnd_a,
  input logic [SHW-1:0]               shamt,
  input logic [WIDTH-1:0]             res_q,
  input logic                         zero_q,
  input logic                         ovf_q
);

  import int_alu_pkg::*;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (res_q == '0 && !zero_q && !ovf_q));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (op_sel != OP_ADD_T && op_sel != OP_SUB_T) |=> !ovf_q);

  a_r5_compare_single_bit: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_LT_S || op_sel == OP_LT_U) |=> (res_q[WIDTH-1:1] == '0));

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (op_sel <= OP_LAST) |=> (zero_q == (res_q == '0)));

  a_r7_shift_by_zero: assert property (@(posedge clk) disable iff (rst)
    ((op_sel == OP_SHL || op_sel == OP_SHR || op_sel == OP_SHRA) && shamt == '0)
      |=> (res_q == $past(opnd_a)));

  a_r9_unused_quiet: assert property (@(posedge clk) disable iff (rst)
    (op_sel > OP_LAST) |=> (res_q == '0 && !zero_q && !ovf_q));

endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH), .SHW(SHW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op_sel (op_sel),
  .opnd_a (opnd_a),
  .shamt  (shamt),
  .res_q  (res_q),
  .zero_q (zero_q),
  .ovf_q  (ovf_q)
);

// File: tb/int_alu_bench.sv
`timescale 1ns/1ps
module int_alu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] res_q;
  logic        zero_q;
  logic        ovf_q;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  int_alu u_int_alu (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .shamt(shamt), .res_q(res_q), .zero_q(zero_q), .ovf_q(ovf_q)
  );

  // Expected behaviour, written from the requirements.
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, output logic [31:0] r, output logic z,
                       output logic o);
    r = '0; o = 1'b0;
    case (op)
      4'd0, 4'd1: begin
        r = a + b;
        if (op == 4'd0) o = (a[31] == b[31]) && (r[31] != a[31]);
      end
      4'd2, 4'd3: begin
        r = a - b;
        if (op == 4'd2) o = (a[31] != b[31]) && (r[31] != a[31]);
      end
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: r = ~(a | b);
      4'd8: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd9: r = (a < b) ? 32'd1 : 32'd0;
      4'd10: r = a << sh;
      4'd11: r = a >> sh;
      4'd12: r = $unsigned($signed(a) >>> sh);
      default: r = '0;
    endcase
    z = (op <= 4'd12) && (r == '0);
  endtask

  task automatic check(input string tag, input logic [31:0] r, input logic z, input logic o,
                       input logic [31:0] er, input logic ez, input logic eo);
    checks++;
    if (r !== er || z !== ez || o !== eo) begin
      errors++;
      $display("FAIL %s: got res=%h zero=%b ovf=%b, expected res=%h zero=%b ovf=%b",
               tag, r, z, o, er, ez, eo);
    end
  endtask

  // Drive on a falling edge, let one rising edge pass, sample on the next falling edge.
  task automatic run_op(input string tag, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] sh);
    logic [31:0] er; logic ez, eo;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; shamt = sh;
    @(negedge clk);
    model(op, a, b, sh, er, ez, eo);
    check(tag, res_q, zero_q, ovf_q, er, ez, eo);
  endtask

  task automatic t_reset;
    @(negedge clk);
    op_sel = 4'd6; opnd_a = 32'hFFFF_0000; opnd_b = 32'h0000_FFFF; rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears outputs", res_q, zero_q, ovf_q, 32'h0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 one-cycle latency after reset", res_q, zero_q, ovf_q, 32'hFFFF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_addsub;
    run_op("R2 add", 4'd0, 32'd1234, 32'd4321, 5'd0);
    run_op("R2 add wrap form", 4'd1, 32'hFFFF_FFFF, 32'd1, 5'd0);
    run_op("R2 sub", 4'd2, 32'd10, 32'd3, 5'd0);
    run_op("R2 sub wrap form", 4'd3, 32'd0, 32'd1, 5'd0);
  endtask

  task automatic t_overflow;
    run_op("R3 add pos overflow", 4'd0, 32'h7FFF_FFFF, 32'd1, 5'd0);
    run_op("R3 add neg overflow", 4'd0, 32'h8000_0000, 32'h8000_0000, 5'd0);
    run_op("R3 add mixed signs", 4'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
    run_op("R3 sub overflow", 4'd2, 32'h8000_0000, 32'd1, 5'd0);
    run_op("R3 sub overflow pos", 4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
    run_op("R3 sub same signs", 4'd2, 32'h8000_0000, 32'h8000_0001, 5'd0);
    run_op("R4 wrap add quiet", 4'd1, 32'h7FFF_FFFF, 32'd1, 5'd0);
    run_op("R4 wrap sub quiet", 4'd3, 32'h8000_0000, 32'd1, 5'd0);
  endtask

  task automatic t_compare;
    run_op("R5 signed 1 vs -1", 4'd8, 32'd1, 32'hFFFF_FFFF, 5'd0);
    check("R5 signed literal", res_q, zero_q, ovf_q, 32'd0, 1'b1, 1'b0);
    run_op("R5 unsigned 1 vs max", 4'd9, 32'd1, 32'hFFFF_FFFF, 5'd0);
    check("R5 unsigned literal", res_q, zero_q, ovf_q, 32'd1, 1'b0, 1'b0);
    run_op("R5 signed -1 vs 0", 4'd8, 32'hFFFF_FFFF, 32'd0, 5'd0);
    run_op("R5 unsigned -1 vs 0", 4'd9, 32'hFFFF_FFFF, 32'd0, 5'd0);
    run_op("R5 signed overflowing diff", 4'd8, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
    run_op("R5 equal", 4'd9, 32'h1234_5678, 32'h1234_5678, 5'd0);
  endtask

  task automatic t_logic;
    run_op("R8 and", 4'd4, 32'hF0F0_1234, 32'hFF00_FF00, 5'd0);
    run_op("R8 or", 4'd5, 32'hF0F0_1234, 32'h0F00_00FF, 5'd0);
    run_op("R8 xor", 4'd6, 32'hAAAA_5555, 32'hFFFF_0000, 5'd0);
    run_op("R8 nor", 4'd7, 32'h0000_0000, 32'h0000_0000, 5'd0);
    check("R8 nor drives all bits", res_q, zero_q, ovf_q, 32'hFFFF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_shift;
    run_op("R7 shl 4", 4'd10, 32'h8123_4567, 32'hDEAD_BEEF, 5'd4);
    run_op("R7 shl 31", 4'd10, 32'h0000_0003, 32'd0, 5'd31);
    run_op("R7 shr 1 neg", 4'd11, 32'h8000_0000, 32'd0, 5'd1);
    run_op("R7 shr 31", 4'd11, 32'hFFFF_FFFF, 32'd0, 5'd31);
    run_op("R7 sra 31 neg", 4'd12, 32'h8000_0000, 32'd0, 5'd31);
    check("R7 sra sign fill literal", res_q, zero_q, ovf_q, 32'hFFFF_FFFF, 1'b0, 1'b0);
    run_op("R7 sra pos", 4'd12, 32'h4000_0000, 32'hFFFF_FFFF, 5'd7);
    run_op("R7 shift by zero", 4'd12, 32'hC001_D00D, 32'd5, 5'd0);
  endtask

  task automatic t_zero;
    run_op("R6 sub equal gives zero", 4'd2, 32'h5A5A_5A5A, 32'h5A5A_5A5A, 5'd0);
    run_op("R6 and gives zero", 4'd4, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 5'd0);
    run_op("R6 shift out gives zero", 4'd10, 32'h8000_0000, 32'd0, 5'd1);
    run_op("R6 nonzero", 4'd5, 32'd0, 32'd1, 5'd0);
  endtask

  task automatic t_unused;
    for (int c = 13; c < 16; c++) begin
      run_op("R9 unused code quiet", 4'(c), 32'h7FFF_FFFF, 32'd1, 5'd3);
      check("R9 literal zero", res_q, zero_q, ovf_q, 32'd0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_addsub();
    t_overflow();
    t_compare();
    t_logic();
    t_shift();
    t_zero();
    t_unused();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule